// File: doc/BRIEF.md
# Lower-Half Memory Map Decoder

This block turns a 16-bit processor address into active-low chip selects for the memories that live in the lower 32K of the address space. It is purely combinational. Each select follows the address, the valid-address strobe and the write strobe within the same cycle, with no register on any path. Decoding is gated by the valid-address strobe and by the top address bit. Outside the lower half, or when the strobe is low, every select stays high.

The lower half is cut into eight 4K blocks by address bits 14 to 12. The two lowest blocks merge into a single 8K save-RAM select. Three blocks feed display, display attribute and acquisition memory. Block 5 is cut in half again by address bit 11, giving command memory and coefficient memory. Blocks 6 and 7 select nothing. A bidirectional data buffer sits in front of the RAM regions. The block drives that buffer's enable and its direction.

The intended user is the bus fabric next to a waveform processor. It wires the selects straight to the chip-select pins of each memory, and the buffer controls straight to the transceiver.

Top module: `amap_decoder`

## Requirements
- R1: When `vma` is 0 or `addr[15]` is 1, every select (`save_n`, `disp_n`, `dattr_n`, `acq_n`, `cmd_n`, `coef_n`) is 1 and `buf_en_n` is 1.
- R2: With decoding enabled, `save_n` is 0 exactly for addresses 0000h to 1FFFh (`addr[14:12]` equal to 0 or 1).
- R3: With decoding enabled, `disp_n` is 0 exactly for 2000h to 2FFFh (block 2), `dattr_n` is 0 exactly for 3000h to 3FFFh (block 3), and `acq_n` is 0 exactly for 4000h to 4FFFh (block 4).
- R4: With decoding enabled, `cmd_n` is 0 exactly for 5000h to 57FFh (block 5 with `addr[11]` = 0).
- R5: With decoding enabled, `coef_n` is 0 exactly for 5800h to 5FFFh (block 5 with `addr[11]` = 1).
- R6: `buf_en_n` is 0 exactly when `save_n`, `cmd_n` or `coef_n` is 0, so the buffer opens for the save RAM and for the whole 5000h to 5FFFh block, and for nothing else.
- R7: `buf_dir` equals `wr` at all times (1 = write, data flows toward the RAM; 0 = read).
- R8: Addresses 6000h to 7FFFh (blocks 6 and 7) assert no select and leave `buf_en_n` at 1.
- R9: At most one of the six selects is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor address bus |
| vma | input | 1 | Valid memory address strobe, active high |
| wr | input | 1 | Write strobe: 1 = write, 0 = read |
| save_n | output | 1 | Save RAM select, 0000h-1FFFh, active low |
| disp_n | output | 1 | Display memory select, active low |
| dattr_n | output | 1 | Display attribute memory select, active low |
| acq_n | output | 1 | Acquisition memory select, active low |
| cmd_n | output | 1 | Command memory select, active low |
| coef_n | output | 1 | Coefficient memory select, active low |
| buf_en_n | output | 1 | RAM data buffer enable, active low |
| buf_dir | output | 1 | RAM data buffer direction, 1 = toward RAM |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the cycle of the stimulus itself, zero cycles later. The bench drives a new address, strobe and write value, waits one time unit for the logic to settle, and only then samples and compares. It never waits on a clock edge. The full sweep covers all 65536 addresses with the strobe both low and high. A random phase and directed corner cases at the block boundaries (1FFFh/2000h, 57FFh/5800h, 5FFFh/6000h, 7FFFh/8000h) then exercise the outputs against bench functions.

// File: rtl/amap_pkg.sv
package amap_pkg;

    // Identity of each 4K block in the lower half of the address space.
    typedef enum logic [2:0] {
        BLK_SAVE_LO = 3'd0,
        BLK_SAVE_HI = 3'd1,
        BLK_DISP    = 3'd2,
        BLK_DATTR   = 3'd3,
        BLK_ACQ     = 3'd4,
        BLK_SPLIT   = 3'd5,
        BLK_SPARE_A = 3'd6,
        BLK_SPARE_B = 3'd7
    } blk_id_e;

    localparam int unsigned BLK_SEL_W = 3;
    localparam int unsigned NUM_BLK   = 1 << BLK_SEL_W;

endpackage

// File: rtl/amap_blk_dec.sv
module amap_blk_dec
    import amap_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               vma,
    output logic [NUM_BLK-1:0] blk_n
);

    localparam int unsigned TOP_BIT = ADDR_W - 1;
    localparam int unsigned SEL_LSB = TOP_BIT - BLK_SEL_W;

    logic                 dec_en;
    logic [BLK_SEL_W-1:0] blk_field;

    assign dec_en    = vma && !addr[TOP_BIT];
    assign blk_field = addr[SEL_LSB +: BLK_SEL_W];

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        assign blk_n[i] = !(dec_en && (blk_field == BLK_SEL_W'(i)));
    end

endmodule

// File: rtl/amap_sub_split.sv
module amap_sub_split (
    input  logic split_blk_n,
    input  logic half_bit,
    output logic lo_half_n,
    output logic hi_half_n
);

    assign lo_half_n = split_blk_n |  half_bit;
    assign hi_half_n = split_blk_n | ~half_bit;

endmodule

// File: rtl/amap_buf_ctrl.sv
module amap_buf_ctrl (
    input  logic save_n,
    input  logic split_blk_n,
    input  logic wr,
    output logic buf_en_n,
    output logic buf_dir
);

    // Negative-logic OR: any low-true RAM region opens the buffer.
    assign buf_en_n = save_n & split_blk_n;
    assign buf_dir  = wr;

endmodule

// File: rtl/amap_decoder.sv
module amap_decoder
    import amap_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              vma,
    input  logic              wr,
    output logic              save_n,
    output logic              disp_n,
    output logic              dattr_n,
    output logic              acq_n,
    output logic              cmd_n,
    output logic              coef_n,
    output logic              buf_en_n,
    output logic              buf_dir
);

    localparam int unsigned HALF_BIT = ADDR_W - 1 - BLK_SEL_W - 1;

    logic [NUM_BLK-1:0] blk_n;

    amap_blk_dec #(.ADDR_W(ADDR_W)) u_blk_dec (
        .addr  (addr),
        .vma   (vma),
        .blk_n (blk_n)
    );

    // Two lowest blocks merge into one save-RAM select (low-true OR).
    assign save_n  = blk_n[BLK_SAVE_LO] & blk_n[BLK_SAVE_HI];
    assign disp_n  = blk_n[BLK_DISP];
    assign dattr_n = blk_n[BLK_DATTR];
    assign acq_n   = blk_n[BLK_ACQ];

    amap_sub_split u_split (
        .split_blk_n (blk_n[BLK_SPLIT]),
        .half_bit    (addr[HALF_BIT]),
        .lo_half_n   (cmd_n),
        .hi_half_n   (coef_n)
    );

    amap_buf_ctrl u_buf (
        .save_n      (save_n),
        .split_blk_n (blk_n[BLK_SPLIT]),
        .wr          (wr),
        .buf_en_n    (buf_en_n),
        .buf_dir     (buf_dir)
    );

endmodule

// File: rtl/amap_decoder_chk.sv
module amap_decoder_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic [ADDR_W-1:0] addr,
    input logic              vma,
    input logic              wr,
    input logic              save_n,
    input logic              disp_n,
    input logic              dattr_n,
    input logic              acq_n,
    input logic              cmd_n,
    input logic              coef_n,
    input logic              buf_en_n,
    input logic              buf_dir
);

    logic [5:0] sel_n;
    logic       on;

    assign sel_n = {save_n, disp_n, dattr_n, acq_n, cmd_n, coef_n};
    assign on    = vma && !addr[ADDR_W-1];

    always_comb begin
        if (!on) begin
            p_quiet_when_off_r1: assert (&sel_n && buf_en_n)
                else $error("R1 select active while decoding disabled");
        end
        if (on && addr[ADDR_W-2 -: 2] == 2'b00) begin
            p_save_low_range_r2: assert (!save_n)
                else $error("R2 save select missing");
        end
        if (!cmd_n) begin
            p_cmd_half_r4: assert (!addr[ADDR_W-5])
                else $error("R4 command select in upper half");
        end
        if (!coef_n) begin
            p_coef_half_r5: assert (addr[ADDR_W-5])
                else $error("R5 coefficient select in lower half");
        end
        p_buf_follows_ram_r6: assert (buf_en_n == (save_n & cmd_n & coef_n))
            else $error("R6 buffer enable mismatch");
        p_dir_is_wr_r7: assert (buf_dir == wr)
            else $error("R7 buffer direction mismatch");
        if (on && addr[ADDR_W-2 -: 2] == 2'b11) begin
            p_spare_quiet_r8: assert (&sel_n && buf_en_n)
                else $error("R8 select in spare blocks");
        end
        p_one_select_r9: assert ($countones(~sel_n) <= 1)
            else $error("R9 more than one select active");
    end

endmodule

bind amap_decoder amap_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .addr     (addr),
    .vma      (vma),
    .wr       (wr),
    .save_n   (save_n),
    .disp_n   (disp_n),
    .dattr_n  (dattr_n),
    .acq_n    (acq_n),
    .cmd_n    (cmd_n),
    .coef_n   (coef_n),
    .buf_en_n (buf_en_n),
    .buf_dir  (buf_dir)
);

// File: tb/tb_amap_decoder.sv
`timescale 1ns/1ps
module tb_amap_decoder;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic [15:0] addr = '0;
    logic        vma = 1'b0;
    logic        wr = 1'b0;
    logic        save_n, disp_n, dattr_n, acq_n, cmd_n, coef_n, buf_en_n, buf_dir;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amap_decoder dut (
        .addr     (addr),
        .vma      (vma),
        .wr       (wr),
        .save_n   (save_n),
        .disp_n   (disp_n),
        .dattr_n  (dattr_n),
        .acq_n    (acq_n),
        .cmd_n    (cmd_n),
        .coef_n   (coef_n),
        .buf_en_n (buf_en_n),
        .buf_dir  (buf_dir)
    );

    // Reference model, written from the requirements.
    function automatic bit exp_on(input logic [15:0] a, input logic v);
        return v && !a[15];
    endfunction
    function automatic logic exp_sel(input logic [15:0] a, input logic v, input int blk);
        return !(exp_on(a, v) && int'(a[14:12]) == blk);
    endfunction
    function automatic logic exp_save(input logic [15:0] a, input logic v);
        return !(exp_on(a, v) && a[14:13] == 2'b00);
    endfunction
    function automatic logic exp_cmd(input logic [15:0] a, input logic v);
        return !(exp_on(a, v) && a[14:11] == 4'b1010);
    endfunction
    function automatic logic exp_coef(input logic [15:0] a, input logic v);
        return !(exp_on(a, v) && a[14:11] == 4'b1011);
    endfunction
    function automatic logic exp_buf(input logic [15:0] a, input logic v);
        return !(exp_on(a, v) && (a[14:13] == 2'b00 || a[14:12] == 3'd5));
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s addr=%h vma=%0b wr=%0b: got %0b expected %0b",
                     req, what, addr, vma, wr, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic v, input logic w);
        logic [5:0] sels;
        addr = a; vma = v; wr = w;
        #1;
        if (!exp_on(a, v)) begin
            chk("R1", "all_idle", &{save_n, disp_n, dattr_n, acq_n, cmd_n, coef_n, buf_en_n}, 1'b1);
        end else if (a[14:13] == 2'b11) begin
            chk("R8", "spare_idle", &{save_n, disp_n, dattr_n, acq_n, cmd_n, coef_n, buf_en_n}, 1'b1);
        end
        chk("R2", "save_n",   save_n,   exp_save(a, v));
        chk("R3", "disp_n",   disp_n,   exp_sel(a, v, 2));
        chk("R3", "dattr_n",  dattr_n,  exp_sel(a, v, 3));
        chk("R3", "acq_n",    acq_n,    exp_sel(a, v, 4));
        chk("R4", "cmd_n",    cmd_n,    exp_cmd(a, v));
        chk("R5", "coef_n",   coef_n,   exp_coef(a, v));
        chk("R6", "buf_en_n", buf_en_n, exp_buf(a, v));
        chk("R7", "buf_dir",  buf_dir,  w);
        sels = {save_n, disp_n, dattr_n, acq_n, cmd_n, coef_n};
        chk("R9", "one_select", ($countones(~sels) <= 1) ? 1'b1 : 1'b0, 1'b1);
        #1;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5A17));
        // Idle state before any access (R1).
        #1;
        chk("R1", "idle_save",  save_n,   1'b1);
        chk("R1", "idle_buf",   buf_en_n, 1'b1);

        // Directed boundary cases.
        apply(16'h0000, 1'b1, 1'b0);
        apply(16'h1FFF, 1'b1, 1'b1);   // R2 top of save RAM
        apply(16'h2000, 1'b1, 1'b0);   // R3 display start
        apply(16'h4FFF, 1'b1, 1'b1);   // R3 acquisition end
        apply(16'h57FF, 1'b1, 1'b0);   // R4 last command word
        apply(16'h5800, 1'b1, 1'b1);   // R5 first coefficient word
        apply(16'h5FFF, 1'b1, 1'b0);
        apply(16'h6000, 1'b1, 1'b1);   // R8 spare start
        apply(16'h7FFF, 1'b1, 1'b0);   // R8 spare end
        apply(16'h8000, 1'b1, 1'b1);   // R1 upper half
        apply(16'h5000, 1'b0, 1'b1);   // R1 strobe low

        // Exhaustive sweep, strobe low and high, random write.
        for (int a = 0; a < 65536; a++) begin
            for (int v = 0; v < 2; v++) begin
                apply(16'(a), 1'(v), 1'($urandom_range(0, 1)));
            end
        end

        // Random phase.
        for (int k = 0; k < 4000; k++) begin
            apply(16'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule